// File: doc/BRIEF.md
# Synchronous Burst Read Address Sequencer

This block is the read path of a 128K x 16 memory. It offers two ways of reading. In the random mode, the external address goes directly to the array and a registered word comes back. In the clocked burst mode, an address-valid strobe loads a start address into an internal counter. Each later clock edge with the strobe released advances the counter by one, and the words stream out behind it. The array is a synchronous memory outside the block. The block gives it an address and a read strobe and registers the word that comes back.

Burst latency depends on the parity of the start word. An even start takes two clocks from the load to the first word. An odd start needs one extra settling edge and so takes three. Every later word follows the edge that requested it by exactly two clocks. A burst has no length limit, and the counter wraps from the top of the array back to zero. If a new load arrives while earlier words are still in flight, those words are discarded.

Top module: `burst_read_seq`

## Requirements
- R1: While `async_sel` is 1, reads are random access and `adv_n` has no effect: the burst counter keeps its value, so a later burst step without a load continues from the old count.
- R2: While `ce_n` is 1 or `we_n` is 0, a clock edge neither loads nor advances the burst counter, whatever the level of `adv_n`.
- R3: A clock edge with `ce_n`=0, `we_n`=1, `async_sel`=0 and `adv_n`=0 loads `addr` into the burst counter.
- R4: A burst-mode clock edge with `adv_n`=1 advances the counter by one. The exception is the settling edge of R5.
- R5: When the loaded address has bit 0 equal to 0, the first word is presented in the cycle after the second edge following the load. When bit 0 is 1, it is presented after the third edge. The edge directly after an odd load is a settling edge and does not advance the counter.
- R6: A word requested by an advance edge is presented in the cycle after the second edge following that advance edge.
- R7: The counter wraps from 1FFFF hex to 00000 hex, and a burst may run any number of words.
- R8: `dq_oe` is 1 exactly when both `ce_n` and `oe_n` are 0.
- R9: `dq_valid` is high for one cycle for each presented word, and `dq_out` holds that word during the same cycle.
- R10: A load edge discards every word still in flight. Only words from the new address appear after it.
- R11: In random mode with `ce_n`=0 and `we_n`=1, the word at the address sampled at edge e is presented, with `dq_valid`=1, in the cycle after edge e+1.
- R12: After a synchronous reset (`rst_n`=0), `dq_valid` is 0 and `arr_rd` is 0 while the chip is deselected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write strobe, active low; a low level marks a write cycle, which the read path ignores |
| async_sel | input | 1 | 1 selects random-access reads, 0 selects clocked burst reads |
| adv_n | input | 1 | Address-valid strobe, active low: low loads, high advances |
| addr | input | 17 | External word address |
| arr_addr | output | 17 | Address presented to the array |
| arr_rd | output | 1 | Array read strobe for the current cycle |
| arr_rdata | input | 16 | Array word, valid one cycle after the read strobe |
| dq_out | output | 16 | Registered data word |
| dq_oe | output | 1 | Output driver enable for the data pins |
| dq_valid | output | 1 | One-cycle flag marking a newly presented word |

## Verification
Bursts are started from even and odd addresses. Comparing the two separates the two-clock first-word latency from the three-clock one, and it shows that the settling edge does not advance the counter. Starts just below the top of the array show whether the wrap to zero is carried through. Reloads mid-burst, including one on the settling edge, show whether stale words leak out. Random-mode traffic with a toggling strobe, deselected cycles and write cycles, each followed by a burst step without a load, shows whether any of them disturbed the counter. Toggling `oe_n` during a burst separates the driver enable from the data flow.

// File: rtl/bsq_pkg.sv
`timescale 1ns/1ps
// Package: shared event type for the burst read sequencer.
// Assumes: one event per clock edge, decided from the pins sampled at that edge.
package bsq_pkg;

    typedef enum logic [1:0] {
        EV_IDLE    = 2'd0,   // no burst activity at this edge
        EV_LOAD    = 2'd1,   // take the external address
        EV_STEP    = 2'd2,   // advance the counter by one
        EV_RELEASE = 2'd3    // settling edge after an odd load
    } bsq_evt_e;

    // Classify one clock edge; a load outranks the settling edge.
    function automatic bsq_evt_e classify(input logic burst_act,
                                          input logic adv_n,
                                          input logic settle);
        if (!burst_act)
            return EV_IDLE;
        else if (!adv_n)
            return EV_LOAD;
        else if (settle)
            return EV_RELEASE;
        else
            return EV_STEP;
    endfunction

endpackage

// File: rtl/bsq_mode_dec.sv
`timescale 1ns/1ps
// Module: bsq_mode_dec
// Decodes the control pins into burst and random-read activity and the
// per-edge burst event. Assumes the pins are stable around the clock edge.
module bsq_mode_dec
    import bsq_pkg::*;
(
    input  logic     ce_n,
    input  logic     we_n,
    input  logic     async_sel,
    input  logic     adv_n,
    input  logic     settle,
    output logic     burst_act,
    output logic     async_act,
    output bsq_evt_e evt
);

    // Purpose: qualify the mode pins by chip enable and by read cycle.
    always_comb begin
        burst_act = !ce_n && we_n && !async_sel;
        async_act = !ce_n && we_n && async_sel;
        evt       = classify(burst_act, adv_n, settle);
    end

endmodule

// File: rtl/bsq_addr_ctrl.sv
`timescale 1ns/1ps
// Module: bsq_addr_ctrl
// Holds the burst counter, the odd-start settling flag and the registered
// read request. Assumes the events come from bsq_mode_dec.
module bsq_addr_ctrl
    import bsq_pkg::*;
#(
    parameter int ADDR_W = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bsq_evt_e          evt,
    input  logic [ADDR_W-1:0] load_addr,
    output logic [ADDR_W-1:0] cnt,
    output logic              settle,
    output logic              rd_q
);

    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

    // Purpose: update counter, settle flag and read request once per edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            settle <= 1'b0;
            rd_q   <= 1'b0;
        end else begin
            case (evt)
                EV_LOAD: begin
                    cnt    <= load_addr;
                    settle <= load_addr[0];
                    rd_q   <= !load_addr[0];
                end
                EV_RELEASE: begin
                    settle <= 1'b0;
                    rd_q   <= 1'b1;
                end
                EV_STEP: begin
                    cnt    <= cnt + ONE;
                    rd_q   <= 1'b1;
                end
                default: begin
                    settle <= 1'b0;
                    rd_q   <= 1'b0;
                end
            endcase
        end
    end

    // R4 and R7: an advance edge adds one, wrapping at the top.
    p_step_adds_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (evt == EV_STEP) |=> (cnt == ADDR_W'($past(cnt) + ONE)));

    // R5: an odd load defers its read by one edge.
    p_odd_defers_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (evt == EV_LOAD && load_addr[0]) |=> (!rd_q && settle));

endmodule

// File: rtl/bsq_out_pipe.sv
`timescale 1ns/1ps
// Module: bsq_out_pipe
// Two-stage valid pipeline with the data output register. Stage one marks
// a word in the array, stage two a word on the outputs. Assumes the array
// returns data one cycle after its read strobe.
module bsq_out_pipe #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_now,
    input  logic              abort,
    input  logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] dq_q,
    output logic              vq
);

    logic v1;

    // Purpose: advance the valid flags and capture data, flushing on abort.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v1   <= 1'b0;
            vq   <= 1'b0;
            dq_q <= '0;
        end else begin
            v1 <= rd_now && !abort;
            vq <= v1 && !abort;
            if (v1 && !abort)
                dq_q <= rdata;
        end
    end

    // R10: nothing from the old burst is presented right after a load.
    p_abort_flushes_r10: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> !vq);

    // R6: a read that survives two edges becomes a presented word.
    p_two_stage_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_now && !abort) ##1 !abort |=> vq);

endmodule

// File: rtl/burst_read_seq.sv
`timescale 1ns/1ps
// Module: burst_read_seq (top)
// Read path offering random-access and clocked linear burst reads of a
// synchronous array. Assumes the array answers one cycle after arr_rd and
// that the mode is not switched while burst reads are still in flight.
module burst_read_seq
    import bsq_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic              async_sel,
    input  logic              adv_n,
    input  logic [ADDR_W-1:0] addr,
    output logic [ADDR_W-1:0] arr_addr,
    output logic              arr_rd,
    input  logic [DATA_W-1:0] arr_rdata,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe,
    output logic              dq_valid
);

    logic              burst_act;
    logic              async_act;
    logic              settle;
    logic              rd_q;
    logic [ADDR_W-1:0] burst_addr;
    bsq_evt_e          evt;

    bsq_mode_dec u_dec (
        .ce_n      (ce_n),
        .we_n      (we_n),
        .async_sel (async_sel),
        .adv_n     (adv_n),
        .settle    (settle),
        .burst_act (burst_act),
        .async_act (async_act),
        .evt       (evt)
    );

    bsq_addr_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt       (evt),
        .load_addr (addr),
        .cnt       (burst_addr),
        .settle    (settle),
        .rd_q      (rd_q)
    );

    // Purpose: steer the array address and read strobe by mode.
    always_comb begin
        arr_addr = async_act ? addr : burst_addr;
        arr_rd   = async_act || rd_q;
    end

    bsq_out_pipe #(.DATA_W(DATA_W)) u_pipe (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_now (arr_rd),
        .abort  (evt == EV_LOAD),
        .rdata  (arr_rdata),
        .dq_q   (dq_out),
        .vq     (dq_valid)
    );

    // Purpose: enable the data drivers only for a selected, enabled chip.
    always_comb dq_oe = !ce_n && !oe_n;

    // R3: a load edge places the external address in the counter.
    p_load_takes_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_act && !adv_n) |=> (burst_addr == $past(addr)));

    // R1: random-mode cycles leave the counter alone.
    p_async_holds_cnt_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && async_sel) |=> $stable(burst_addr));

    // R2: deselected or write cycles leave the counter alone.
    p_inactive_holds_cnt_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_n || !we_n) |=> $stable(burst_addr));

endmodule

// File: tb/burst_read_seq_tb_top.sv
`timescale 1ns/1ps
// Bench: a behavioural reference model (event queue keyed by edge number)
// compared against the outputs on every clock.
module burst_read_seq_tb_top;

    localparam int AW = 17;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_n = 1'b1;
    logic          oe_n = 1'b1;
    logic          we_n = 1'b1;
    logic          async_sel = 1'b0;
    logic          adv_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [AW-1:0] arr_addr;
    logic          arr_rd;
    logic [DW-1:0] arr_rdata = '0;
    logic [DW-1:0] dq_out;
    logic          dq_oe;
    logic          dq_valid;

    always #2.5 clk = ~clk;

    burst_read_seq dut_i (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .async_sel(async_sel), .adv_n(adv_n), .addr(addr),
        .arr_addr(arr_addr), .arr_rd(arr_rd), .arr_rdata(arr_rdata),
        .dq_out(dq_out), .dq_oe(dq_oe), .dq_valid(dq_valid)
    );

    // Array content is computed from the address.
    function automatic logic [DW-1:0] mem_word(input logic [AW-1:0] a);
        return a[15:0] ^ {a[16], a[16:2]} ^ 16'hC3A5;
    endfunction

    always @(posedge clk) if (arr_rd) arr_rdata <= mem_word(arr_addr);

    int    vectors = 0;
    int    miscompares = 0;
    bit    done = 1'b0;
    bit    checking = 1'b0;
    string cur_req = "R12";

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s: actual=%h expected=%h at %0t", req, what, act, exp, $time);
        end
    endtask

    // Reference model state.
    typedef struct { int due; logic [AW-1:0] a; } slot_t;
    slot_t         q[$];
    int            edge_n = 0;
    logic [AW-1:0] m_cnt = '0;
    bit            m_settle = 1'b0;
    bit            exp_v;
    logic [DW-1:0] exp_d;

    always @(posedge clk) begin
        edge_n++;
        if (!rst_n) begin
            q.delete();
            m_cnt = '0;
            m_settle = 1'b0;
        end else begin : model
            bit burst;
            bit asy;
            burst = !ce_n && !async_sel && we_n;
            asy   = !ce_n && async_sel && we_n;
            if (asy) q.push_back('{edge_n + 1, addr});               // R11
            if (burst && !adv_n) begin                                // R3, R10
                q.delete();
                m_cnt = addr;
                m_settle = addr[0];
                if (!addr[0]) q.push_back('{edge_n + 2, addr});       // R5 even
            end else if (burst && m_settle) begin                     // R5 odd
                m_settle = 1'b0;
                q.push_back('{edge_n + 2, m_cnt});
            end else if (burst) begin                                 // R4, R6, R7
                m_cnt = m_cnt + 1'b1;
                q.push_back('{edge_n + 2, m_cnt});
            end else begin
                m_settle = 1'b0;                                      // R1, R2
            end
        end
        exp_v = 1'b0;
        exp_d = '0;
        if (q.size() > 0 && q[0].due == edge_n) begin
            exp_v = 1'b1;
            exp_d = mem_word(q[0].a);
            void'(q.pop_front());
        end
        #1;
        if (checking) begin
            check(cur_req, "dq_valid (R9)", {31'd0, dq_valid}, {31'd0, exp_v});
            if (exp_v) check(cur_req, "dq_out (R9)", {16'd0, dq_out}, {16'd0, exp_d});
            check("R8", "dq_oe", {31'd0, dq_oe}, {31'd0, (!ce_n && !oe_n)});
        end
    end

    task automatic drive(input bit c, input bit as, input bit w, input bit o,
                         input bit ad, input logic [AW-1:0] a);
        @(negedge clk);
        ce_n = c; async_sel = as; we_n = w; oe_n = o; adv_n = ad; addr = a;
    endtask

    task automatic idle(input int k);
        for (int i = 0; i < k; i++) drive(1, 0, 1, 1, 1, '0);
    endtask

    task automatic bload(input logic [AW-1:0] a); drive(0, 0, 1, 0, 0, a); endtask
    task automatic bstep(); drive(0, 0, 1, 0, 1, 17'h0); endtask

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    initial begin : watchdog
        #1000000;
        if (!done) begin
            miscompares++;
            $display("FAIL %s watchdog: actual=hung expected=finished", cur_req);
            finish_run();
        end
    end

    initial begin
        // R12: reset state while deselected.
        idle(4);
        @(posedge clk); #1;
        check("R12", "dq_valid after reset", {31'd0, dq_valid}, 32'd0);
        check("R12", "arr_rd after reset", {31'd0, arr_rd}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        checking = 1'b1;
        idle(2);

        // R3 R4 R5 R6 R9: even start, two-clock first word.
        cur_req = "R3/R4/R5/R6/R9";
        bload(17'h00010);
        repeat (6) bstep();
        idle(3);

        // R5: odd start with settling edge.
        cur_req = "R5";
        bload(17'h00123);
        repeat (6) bstep();
        idle(3);

        // R7: wrap from the top of the array, even and odd starts.
        cur_req = "R7";
        bload(17'h1FFFC);
        repeat (8) bstep();
        idle(3);
        bload(17'h1FFFF);
        repeat (4) bstep();
        idle(3);

        // R10: reload mid-burst and on the settling edge.
        cur_req = "R10";
        bload(17'h00400);
        bstep();
        bstep();
        bload(17'h00800);
        repeat (4) bstep();
        bload(17'h00901);
        bload(17'h00A00);
        repeat (3) bstep();
        idle(3);

        // R11 R1: random reads with the strobe toggling.
        cur_req = "R11/R1";
        drive(0, 1, 1, 0, 0, 17'h0F0F0);
        drive(0, 1, 1, 0, 1, 17'h10001);
        drive(0, 1, 1, 0, 0, 17'h00007);
        drive(0, 1, 1, 1, 1, 17'h1ABCD);
        drive(0, 1, 1, 0, 0, 17'h03333);
        drive(0, 1, 1, 0, 1, 17'h1FFFF);
        idle(3);
        // R1: counter kept; steps continue from 00A03.
        cur_req = "R1";
        bstep();
        bstep();
        idle(3);

        // R2: deselected and write cycles do not load or advance.
        cur_req = "R2";
        drive(1, 0, 1, 0, 0, 17'h15555);
        drive(1, 0, 1, 0, 1, 17'h15555);
        drive(0, 0, 0, 1, 0, 17'h0AAAA);
        drive(0, 0, 0, 1, 1, 17'h0AAAA);
        idle(2);
        bstep();
        bstep();
        idle(3);

        // R8: output enable toggled during a burst.
        cur_req = "R8";
        drive(0, 0, 1, 1, 0, 17'h02000);
        drive(0, 0, 1, 0, 1, 17'h0);
        drive(0, 0, 1, 1, 1, 17'h0);
        drive(0, 0, 1, 0, 1, 17'h0);
        drive(0, 0, 1, 1, 1, 17'h0);
        idle(4);

        done = 1'b1;
        finish_run();
    end

endmodule